// File: doc/BRIEF.md
# Open-Loop Volts-per-Hertz Sinusoidal Commutator

This block turns a speed command into three PWM duty words for driving a three-phase motor without feedback. Each time the sample strobe fires, an electrical-angle phase accumulator steps forward by the speed command. The speed command is the angle increment per sample, so the electrical frequency is `speed_cmd * f_sample / 2^16`. The output voltage magnitude is derived from the same command through a programmable volts-per-hertz gain. As a result, the applied voltage grows in proportion to the electrical frequency.

The angle and the magnitude feed an inverse Park stage. The rotating-frame vector is placed on the direct axis, with the quadrature component held at zero. The stationary alpha/beta result is split into three phase voltages. Space vector modulation then centres them in the PWM period through min/max zero-sequence injection. The magnitude is clamped at the linear-range limit of that modulation, so every duty word stays within the period. The PWM period is sampled with each strobe, and the three duty words appear together with a one-cycle valid pulse at a fixed latency.

Top module: `vhz_commutator`

## Requirements
- R1: While reset is asserted and after it is released, with no sample strobe seen, `angle_o` is 0, all three duty outputs are 0 and `duty_valid` is 0.
- R2: At each clock edge where `sample_stb` is 1, `angle_o` becomes `(angle_o + speed_cmd) mod 2^16`, where 2^16 counts one electrical turn. At every other edge `angle_o` holds its value.
- R3: `duty_valid` is 1 in exactly those cycles that come 5 clock edges after an edge at which `sample_stb` was 1. The duty outputs change only at edges where `duty_valid` becomes or stays 1.
- R4: The voltage magnitude M for a sample is `floor(speed_cmd * vhz_gain / 256)`, with `vhz_gain` in unsigned 8.8 fixed point. M is limited to `floor(pwm_period * 37837 / 65536)`, which is the period divided by the square root of 3.
- R5: The phase voltages are U = M·cos θ, V = M·cos(θ − 120°) and W = M·cos(θ + 120°). Here θ is the new `angle_o` value with its 6 low bits replaced by 32, which is the centre of the sine table step, scaled so that 2^16 equals 360°.
- R6: Each duty equals `pwm_period/2 + Vx − (max(U,V,W) + min(U,V,W))/2`, rounded to within ±4 counts.
- R7: Every duty word lies in the range 0 to the `pwm_period` sampled with its strobe, inclusive.
- R8: With `speed_cmd` equal to 0, all three duty words equal `floor(pwm_period/2)` exactly.
- R9: The duty words for a sample use the `pwm_period`, `speed_cmd` and `vhz_gain` present at that sample's strobe. Changes to these inputs between strobes do not affect a sample already started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_stb | input | 1 | One-cycle sample event |
| speed_cmd | input | 16 | Angle increment per sample (2^16 = one turn) |
| vhz_gain | input | 16 | Volts-per-hertz gain, unsigned 8.8 |
| pwm_period | input | 16 | PWM period in counts |
| angle_o | output | 16 | Current electrical angle |
| duty_u | output | 16 | Phase U duty in counts |
| duty_v | output | 16 | Phase V duty in counts |
| duty_w | output | 16 | Phase W duty in counts |
| duty_valid | output | 1 | Duty words updated this cycle |

## Verification
The bound checker checks these properties on every cycle:
- The angle stepping and holding rule.
- The exact five-edge latency of the valid pulse.
- That the duty words hold still between pulses.
- That each duty word stays within its sampled period.
- That a zero speed command gives duty words exactly at mid-period.

Only the bench's scenarios can show the following, because they need a real-valued model of the waveform:
- The volts-per-hertz scaling and its clamp.
- The sinusoidal shape and 120° phase spacing.
- The zero-sequence centring.
- Wrap-around of the angle.
- The use of the period captured at the strobe when the period later changes.

// File: rtl/vhz_pkg.sv
package vhz_pkg;
  // 1/sqrt(3) and sqrt(3)/2 in unsigned Q0.16
  localparam int unsigned INV_SQRT3_Q16  = 37837;
  localparam int unsigned HALF_SQRT3_Q16 = 56756;
  // pi in Q28 for the table builder
  localparam longint     PI_Q28         = 64'sd843314857;
  // fixed pipeline depth from strobe to duty_valid
  localparam int unsigned PIPE_DEPTH     = 5;
endpackage

// File: rtl/vhz_rst_sync.sv
module vhz_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/vhz_trig_rom.sv
module vhz_trig_rom import vhz_pkg::*; #(
  parameter int ANG_W  = 16,
  parameter int TRIG_W = 14,
  parameter int LUT_AW = 8
) (
  input  logic        [ANG_W-1:0]  angle_i,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  localparam int ENTRIES = 1 << LUT_AW;
  localparam int MAG_W   = TRIG_W - 1;
  localparam longint AMP = (64'sd1 <<< MAG_W) - 64'sd1;
  localparam logic [ANG_W-1:0] QUARTER = ANG_W'(1) << (ANG_W - 2);

  // sin((i + 0.5) * pi / (2 * ENTRIES)) by Taylor series to x^11 in Q28
  function automatic logic [MAG_W-1:0] quarter_sine(input int i);
    longint x;
    longint x2;
    longint term;
    longint sum;
    x    = (longint'(2 * i + 1) * PI_Q28) / longint'(4 * ENTRIES);
    x2   = (x * x) >>> 28;
    term = x;
    sum  = x;
    for (int k = 1; k <= 5; k++) begin
      term = -((term * x2) >>> 28) / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    return MAG_W'((sum * AMP + (64'sd1 <<< 27)) >>> 28);
  endfunction

  logic [MAG_W-1:0] lut [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_lut
    assign lut[g] = quarter_sine(g);
  end

  // port 0 = sine of angle, port 1 = sine of angle + 90 deg = cosine
  logic        [ANG_W-1:0]  port_ang [2];
  logic signed [TRIG_W-1:0] port_val [2];

  assign port_ang[0] = angle_i;
  assign port_ang[1] = angle_i + QUARTER;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx;
    logic [MAG_W-1:0]  amp;
    always_comb begin
      quad = port_ang[p][ANG_W-1 -: 2];
      idx  = port_ang[p][ANG_W-3 -: LUT_AW];
      if (quad[0]) idx = ~idx;
      amp  = lut[idx];
      if (quad[1]) port_val[p] = -$signed({1'b0, amp});
      else         port_val[p] =  $signed({1'b0, amp});
    end
  end

  assign sin_o = port_val[0];
  assign cos_o = port_val[1];
endmodule

// File: rtl/vhz_svm.sv
module vhz_svm import vhz_pkg::*; #(
  parameter int PER_W = 16,
  parameter int PV_W  = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic signed [PV_W-1:0]  alpha_i,
  input  logic signed [PV_W-1:0]  beta_i,
  input  logic        [PER_W-1:0] per_i,
  output logic        [PER_W-1:0] duty_o [3],
  output logic                    vld_o
);
  localparam int KW = PV_W + 17;
  localparam int DW = PV_W + 2;

  // ---- stage 4: inverse Clarke into three phase voltages
  logic signed [KW-1:0]   k_prod;
  logic signed [PV_W-1:0] k_term;
  logic signed [PV_W-1:0] half_a;
  logic signed [PV_W-1:0] ph_nxt [3];
  logic signed [PV_W-1:0] ph_q   [3];
  logic        [PER_W-1:0] per4_q;
  logic                   vld4_q;

  always_comb begin
    k_prod    = $signed({{(KW-PV_W){beta_i[PV_W-1]}}, beta_i}) *
                $signed(KW'(HALF_SQRT3_Q16));
    k_term    = PV_W'(k_prod >>> 16);
    half_a    = alpha_i >>> 1;
    ph_nxt[0] = alpha_i;
    ph_nxt[1] = k_term - half_a;
    ph_nxt[2] = -half_a - k_term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld4_q <= 1'b0;
      per4_q <= '0;
      for (int i = 0; i < 3; i++) ph_q[i] <= '0;
    end else begin
      vld4_q <= vld_i;
      if (vld_i) begin
        per4_q <= per_i;
        for (int i = 0; i < 3; i++) ph_q[i] <= ph_nxt[i];
      end
    end
  end

  // ---- stage 5: min/max zero-sequence injection and centring
  logic signed [PV_W-1:0] ph_max;
  logic signed [PV_W-1:0] ph_min;
  logic signed [DW-1:0]   zero_seq;
  logic signed [DW-1:0]   mid;
  logic        [PER_W-1:0] duty_nxt [3];
  logic        [PER_W-1:0] duty_q   [3];
  logic                   vld5_q;

  always_comb begin
    ph_max = ph_q[0];
    ph_min = ph_q[0];
    for (int i = 1; i < 3; i++) begin
      if (ph_q[i] > ph_max) ph_max = ph_q[i];
      if (ph_q[i] < ph_min) ph_min = ph_q[i];
    end
    zero_seq = (DW'(ph_max) + DW'(ph_min)) >>> 1;
    mid      = $signed(DW'({1'b0, per4_q >> 1}));
  end

  for (genvar p = 0; p < 3; p++) begin : g_phase
    logic signed [DW-1:0] raw;
    always_comb begin
      raw = mid + DW'(ph_q[p]) - zero_seq;
      if (raw < 0)                                duty_nxt[p] = '0;
      else if (raw > $signed(DW'({1'b0, per4_q}))) duty_nxt[p] = per4_q;
      else                                        duty_nxt[p] = raw[PER_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld5_q <= 1'b0;
      for (int i = 0; i < 3; i++) duty_q[i] <= '0;
    end else begin
      vld5_q <= vld4_q;
      if (vld4_q) begin
        for (int i = 0; i < 3; i++) duty_q[i] <= duty_nxt[i];
      end
    end
  end

  assign duty_o = duty_q;
  assign vld_o  = vld5_q;
endmodule

// File: rtl/vhz_commutator.sv
module vhz_commutator import vhz_pkg::*; #(
  parameter int ANG_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int PER_W     = 16,
  parameter int TRIG_W    = 14,
  parameter int LUT_AW    = 8,
  parameter int GAIN_FRAC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [ANG_W-1:0] speed_cmd,
  input  logic [GAIN_W-1:0] vhz_gain,
  input  logic [PER_W-1:0] pwm_period,
  output logic [ANG_W-1:0] angle_o,
  output logic [PER_W-1:0] duty_u,
  output logic [PER_W-1:0] duty_v,
  output logic [PER_W-1:0] duty_w,
  output logic             duty_valid
);
  localparam int PROD_W = ANG_W + GAIN_W;
  localparam int LIM_W  = PER_W + 16;
  localparam int PV_W   = PER_W + 2;
  localparam int MUL_W  = PER_W + 1 + TRIG_W;

  logic rst_int_n;

  vhz_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  // ---- stage 1: angle ramp and volts-per-hertz magnitude
  logic [PROD_W-1:0] vhz_prod;
  logic [PROD_W-1:0] vhz_scaled;
  logic [LIM_W-1:0]  lim_prod;
  logic [PER_W-1:0]  mag_lim;
  logic [PER_W-1:0]  mag_nxt;
  logic [ANG_W-1:0]  angle_nxt;

  always_comb begin
    vhz_prod   = PROD_W'(speed_cmd) * PROD_W'(vhz_gain);
    vhz_scaled = vhz_prod >> GAIN_FRAC;
    lim_prod   = LIM_W'(pwm_period) * LIM_W'(INV_SQRT3_Q16);
    mag_lim    = lim_prod[LIM_W-1:16];
    if (vhz_scaled > PROD_W'(mag_lim)) mag_nxt = mag_lim;
    else                               mag_nxt = vhz_scaled[PER_W-1:0];
    angle_nxt  = angle_q + speed_cmd;
  end

  logic [ANG_W-1:0] angle_q;
  logic [PER_W-1:0] mag1_q;
  logic [PER_W-1:0] per1_q;
  logic             vld1_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld1_q  <= 1'b0;
      angle_q <= '0;
      mag1_q  <= '0;
      per1_q  <= '0;
    end else begin
      vld1_q <= sample_stb;
      if (sample_stb) begin
        angle_q <= angle_nxt;
        mag1_q  <= mag_nxt;
        per1_q  <= pwm_period;
      end
    end
  end

  // ---- stage 2: sine / cosine lookup
  logic signed [TRIG_W-1:0] sin_w;
  logic signed [TRIG_W-1:0] cos_w;

  vhz_trig_rom #(
    .ANG_W  (ANG_W),
    .TRIG_W (TRIG_W),
    .LUT_AW (LUT_AW)
  ) u_rom (
    .angle_i (angle_q),
    .sin_o   (sin_w),
    .cos_o   (cos_w)
  );

  logic signed [TRIG_W-1:0] sin2_q;
  logic signed [TRIG_W-1:0] cos2_q;
  logic        [PER_W-1:0]  mag2_q;
  logic        [PER_W-1:0]  per2_q;
  logic                     vld2_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld2_q <= 1'b0;
      sin2_q <= '0;
      cos2_q <= '0;
      mag2_q <= '0;
      per2_q <= '0;
    end else begin
      vld2_q <= vld1_q;
      if (vld1_q) begin
        sin2_q <= sin_w;
        cos2_q <= cos_w;
        mag2_q <= mag1_q;
        per2_q <= per1_q;
      end
    end
  end

  // ---- stage 3: inverse Park with the vector on the direct axis
  logic signed [MUL_W-1:0] mag_ext;
  logic signed [MUL_W-1:0] alpha_prod;
  logic signed [MUL_W-1:0] beta_prod;
  logic signed [PV_W-1:0]  alpha_nxt;
  logic signed [PV_W-1:0]  beta_nxt;

  always_comb begin
    mag_ext    = $signed(MUL_W'(mag2_q));
    alpha_prod = mag_ext * $signed({{(MUL_W-TRIG_W){cos2_q[TRIG_W-1]}}, cos2_q});
    beta_prod  = mag_ext * $signed({{(MUL_W-TRIG_W){sin2_q[TRIG_W-1]}}, sin2_q});
    alpha_nxt  = PV_W'(alpha_prod >>> (TRIG_W - 1));
    beta_nxt   = PV_W'(beta_prod  >>> (TRIG_W - 1));
  end

  logic signed [PV_W-1:0]  alpha3_q;
  logic signed [PV_W-1:0]  beta3_q;
  logic        [PER_W-1:0] per3_q;
  logic                    vld3_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld3_q   <= 1'b0;
      alpha3_q <= '0;
      beta3_q  <= '0;
      per3_q   <= '0;
    end else begin
      vld3_q <= vld2_q;
      if (vld2_q) begin
        alpha3_q <= alpha_nxt;
        beta3_q  <= beta_nxt;
        per3_q   <= per2_q;
      end
    end
  end

  // ---- stages 4 and 5: phase split and space vector modulation
  logic [PER_W-1:0] duty_w_arr [3];

  vhz_svm #(
    .PER_W (PER_W),
    .PV_W  (PV_W)
  ) u_svm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .vld_i   (vld3_q),
    .alpha_i (alpha3_q),
    .beta_i  (beta3_q),
    .per_i   (per3_q),
    .duty_o  (duty_w_arr),
    .vld_o   (duty_valid)
  );

  assign angle_o = angle_q;
  assign duty_u  = duty_w_arr[0];
  assign duty_v  = duty_w_arr[1];
  assign duty_w  = duty_w_arr[2];
endmodule

// File: rtl/vhz_commutator_chk.sv
module vhz_commutator_chk #(
  parameter int ANG_W = 16,
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_stb,
  input logic [ANG_W-1:0] speed_cmd,
  input logic [PER_W-1:0] pwm_period,
  input logic [ANG_W-1:0] angle_o,
  input logic [PER_W-1:0] duty_u,
  input logic [PER_W-1:0] duty_v,
  input logic [PER_W-1:0] duty_w,
  input logic             duty_valid
);
  // cycles since reset release, saturating, so history checks never
  // reach back into reset
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3'd6) since_rst <= since_rst + 3'd1;
  end
  logic hist_ok;
  assign hist_ok = (since_rst >= 3'd6);

  a_r2_angle_step: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> angle_o == ANG_W'($past(angle_o) + $past(speed_cmd)));

  a_r2_angle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(angle_o));

  a_r3_valid_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(sample_stb, 5)) |-> duty_valid);

  a_r3_valid_only_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && duty_valid) |-> $past(sample_stb, 5));

  a_r3_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_valid |-> ($stable(duty_u) && $stable(duty_v) && $stable(duty_w)));

  a_r7_duty_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && duty_valid) |->
      (duty_u <= $past(pwm_period, 5) && duty_v <= $past(pwm_period, 5) &&
       duty_w <= $past(pwm_period, 5)));

  a_r8_zero_speed_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && duty_valid && $past(speed_cmd, 5) == '0) |->
      (duty_u == ($past(pwm_period, 5) >> 1) && duty_v == ($past(pwm_period, 5) >> 1) &&
       duty_w == ($past(pwm_period, 5) >> 1)));
endmodule

bind vhz_commutator vhz_commutator_chk #(
  .ANG_W (ANG_W),
  .PER_W (PER_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .sample_stb (sample_stb),
  .speed_cmd  (speed_cmd),
  .pwm_period (pwm_period),
  .angle_o    (angle_o),
  .duty_u     (duty_u),
  .duty_v     (duty_v),
  .duty_w     (duty_w),
  .duty_valid (duty_valid)
);

// File: tb/vhz_commutator_test.sv
`timescale 1ns/1ps
module vhz_commutator_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_stb;
  logic [15:0] speed_cmd;
  logic [15:0] vhz_gain;
  logic [15:0] pwm_period;
  logic [15:0] angle_o;
  logic [15:0] duty_u, duty_v, duty_w;
  logic        duty_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int unsigned exp_angle = 0;

  always #2.5 clk = ~clk;

  vhz_commutator uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .speed_cmd  (speed_cmd),
    .vhz_gain   (vhz_gain),
    .pwm_period (pwm_period),
    .angle_o    (angle_o),
    .duty_u     (duty_u),
    .duty_v     (duty_v),
    .duty_w     (duty_w),
    .duty_valid (duty_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_mag(input longint spd, input longint gain, input longint per);
    longint m, lim;
    m   = (spd * gain) / 256;
    lim = (per * 37837) / 65536;
    return (m > lim) ? lim : m;
  endfunction

  // expected duty per phase from the real-valued model (R4, R5, R6)
  task automatic model(input int unsigned ang, input longint mag, input longint per,
                       output real d [3]);
    real th, v [3], mx, mn;
    th = 2.0 * 3.14159265358979 * real'((ang & 32'hFFC0) + 32) / 65536.0;
    for (int k = 0; k < 3; k++)
      v[k] = real'(mag) * $cos(th - real'(k) * 2.0 * 3.14159265358979 / 3.0);
    mx = v[0]; mn = v[0];
    for (int k = 1; k < 3; k++) begin
      if (v[k] > mx) mx = v[k];
      if (v[k] < mn) mn = v[k];
    end
    for (int k = 0; k < 3; k++) d[k] = real'(per) / 2.0 + v[k] - (mx + mn) / 2.0;
  endtask

  function automatic bit near(input longint a, input real e);
    real diff;
    diff = real'(a) - e;
    return (diff <= 4.0) && (diff >= -4.0);
  endfunction

  // one sample: strobe, check angle, valid timing, duty values
  task automatic run_sample(input logic [15:0] spd, input logic [15:0] gain,
                            input logic [15:0] per, input bool_scramble);
    real    d [3];
    longint mag;
    longint act [3];
    logic [15:0] du, dv, dw;
    speed_cmd  = spd;
    vhz_gain   = gain;
    pwm_period = per;
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    if (bool_scramble) begin
      // R9: inputs changing after the strobe must not affect this sample
      speed_cmd  = 16'h7777;
      vhz_gain   = 16'hFFFF;
      pwm_period = 16'd9;
    end
    exp_angle = (exp_angle + spd) % 65536;
    chk(angle_o == exp_angle[15:0], "R2", "angle after strobe", angle_o, exp_angle);
    for (int i = 0; i < 3; i++) begin
      chk(duty_valid == 1'b0, "R3", "valid early", duty_valid, 0);
      @(negedge clk);
    end
    chk(duty_valid == 1'b0, "R3", "valid early", duty_valid, 0);
    @(negedge clk);
    chk(duty_valid == 1'b1, "R3", "valid at latency 5", duty_valid, 1);
    mag = exp_mag(spd, gain, per);
    model(exp_angle, mag, per, d);
    act[0] = duty_u; act[1] = duty_v; act[2] = duty_w;
    for (int k = 0; k < 3; k++) begin
      chk(near(act[k], d[k]), "R6", "duty vs model", act[k], longint'(d[k]));
      chk(act[k] <= per, "R7", "duty within period", act[k], per);
    end
    du = duty_u; dv = duty_v; dw = duty_w;
    @(negedge clk);
    chk(duty_valid == 1'b0, "R3", "valid single cycle", duty_valid, 0);
    chk(duty_u == du && duty_v == dv && duty_w == dw, "R3", "duty held",
        duty_u, du);
    speed_cmd = spd; vhz_gain = gain; pwm_period = per;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; sample_stb = 1'b0;
    speed_cmd = '0; vhz_gain = '0; pwm_period = 16'd1000;
    repeat (4) @(negedge clk);
    chk(angle_o == 0 && duty_valid == 0, "R1", "in reset angle/valid", angle_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(angle_o == 0, "R1", "angle after reset", angle_o, 0);
    chk(duty_u == 0 && duty_v == 0 && duty_w == 0, "R1", "duties after reset", duty_u, 0);
    chk(duty_valid == 0, "R1", "valid after reset", duty_valid, 0);
    exp_angle = 0;
  endtask

  task automatic test_zero_speed();
    run_sample(16'd0, 16'd512, 16'd1000, 1'b0);
    chk(duty_u == 500 && duty_v == 500 && duty_w == 500, "R8", "zero speed mid", duty_u, 500);
    run_sample(16'd0, 16'd512, 16'd777, 1'b0);
    chk(duty_u == 388 && duty_v == 388 && duty_w == 388, "R8", "zero speed odd period", duty_u, 388);
  endtask

  task automatic test_sweep();
    // R4 R5: magnitude proportional to speed, sinusoidal phases
    for (int i = 0; i < 10; i++) run_sample(16'd3100, 16'd26, 16'd1000, 1'b0);
    for (int i = 0; i < 6; i++)  run_sample(16'd7000, 16'd12, 16'd1000, 1'b0);
  endtask

  task automatic test_wrap();
    // R2: accumulator wraps modulo 2^16
    for (int i = 0; i < 4; i++) run_sample(16'd60000, 16'd2, 16'd1000, 1'b0);
  endtask

  task automatic test_saturation();
    // R4 R7: magnitude clamped to period/sqrt(3)
    for (int i = 0; i < 6; i++) run_sample(16'd4000, 16'd4096, 16'd1000, 1'b0);
  endtask

  task automatic test_period_capture();
    // R9: period captured at strobe; later input changes ignored
    run_sample(16'd500, 16'd512, 16'd2000, 1'b1);
    run_sample(16'd900, 16'd300, 16'd1500, 1'b1);
  endtask

  task automatic test_idle();
    logic [15:0] a0, du;
    bit seen;
    a0 = angle_o; du = duty_u; seen = 1'b0;
    speed_cmd = 16'd1234;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (duty_valid) seen = 1'b1;
    end
    chk(angle_o == a0, "R2", "angle holds without strobe", angle_o, a0);
    chk(!seen, "R3", "no valid without strobe", seen, 0);
    chk(duty_u == du, "R3", "duty holds without strobe", duty_u, du);
  endtask

  task automatic test_back_to_back();
    int cnt;
    cnt = 0;
    speed_cmd = 16'd1000; vhz_gain = 16'd256; pwm_period = 16'd1000;
    sample_stb = 1'b1;
    repeat (3) @(negedge clk);
    sample_stb = 1'b0;
    exp_angle = (exp_angle + 3000) % 65536;
    chk(angle_o == exp_angle[15:0], "R2", "angle after 3 strobes", angle_o, exp_angle);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (duty_valid) cnt++;
      if (i == 1) chk(duty_valid == 1'b1, "R3", "first b2b valid", duty_valid, 1);
      if (i == 4) chk(duty_valid == 1'b0, "R3", "b2b valid ended", duty_valid, 0);
    end
    chk(cnt == 3, "R3", "b2b valid count", cnt, 3);
  endtask

  initial begin
    test_reset();
    test_zero_speed();
    test_sweep();
    test_wrap();
    test_saturation();
    test_period_capture();
    test_idle();
    test_back_to_back();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule